// File: doc/BRIEF.md
# Quadrature Sine Generator with First-Order Taylor Correction

The block turns a phase word into a sine and a cosine sample on every clock. The upper bits of the phase select a coarse angle in a quarter-wave-free, full-cycle sine table. The table is read through two ports in the same cycle: one port at the coarse address, the other a quarter cycle further on, so both sin(θc) and cos(θc) are available at once. The lower phase bits form a residual angle δ, which is scaled to radians by a fixed-point constant. Because each function is the derivative of the other, the block refines both outputs with a single multiply-add each: the sine gains δ·cos(θc), and the cosine loses δ·sin(θc). No separate slope or derivative table is stored.

A phase word with a valid flag enters on each clock, with no handshake. Corrected samples leave three register stages later with a matching valid flag. Results are clamped to the signed output range. Sample rate equals clock rate, so a phase accumulator can feed the block directly.

Top module: `quad_taylor_gen`

## Requirements
- R1: While `rst` is high at a rising edge, the next state has `out_valid` = 0, `sin_out` = 0 and `cos_out` = 0.
- R2: `out_valid` after the third rising edge counted from the edge that samples `in_valid` equals that sampled `in_valid`. Back-to-back inputs give back-to-back results, and gaps are kept.
- R3: For a valid phase p, `sin_out` lies within 2 LSB of 32767·sin(2π·p/2^24) (default widths).
- R4: For a valid phase p, `cos_out` lies within 2 LSB of 32767·cos(2π·p/2^24) (default widths).
- R5: The table is addressed by the top 10 phase bits and holds round(32767·sin(2π·i/1024)), with ties rounded away from zero. When the lower 14 phase bits are zero, `sin_out` equals entry i and `cos_out` equals entry (i+256) mod 1024 exactly.
- R6: The cosine address wraps modulo the table depth, so phases in the last quarter cycle (top two bits 11) still meet the R4 tolerance.
- R7: Corrected results beyond the signed output range are clamped to +32767 or −32768 and never wrap.
- R8: While `in_valid` is low, `phase_in` has no effect: `sin_out` and `cos_out` keep the last result once the pipeline has drained.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Phase word on `phase_in` is to be converted |
| phase_in | input | PHASE_W (24) | Unsigned phase, full scale = one cycle |
| out_valid | output | 1 | `sin_out`/`cos_out` hold a new result |
| sin_out | output | AMP_W (16) | Corrected sine, signed two's complement |
| cos_out | output | AMP_W (16) | Corrected cosine, signed two's complement |

## Verification
The bench builds two instances. The default one has a 24-bit phase and a 1024-entry table. It is compared against real-valued sine and cosine references across all four quadrants, including the wrap of the cosine port. The second instance has only a 64-entry table. Its coarse step is wide enough that the first-order estimate near a peak overshoots full scale by about 160 LSB, so the clamping path becomes reachable. With the default table it never is.

// File: rtl/qtg_pkg.sv
package qtg_pkg;

  localparam real TWO_PI = 6.283185307179586;

  // Fractional bits added to the radians-per-phase-LSB constant.
  localparam int KQ = 12;

  // Sign of the derivative term applied by a correction lane.
  typedef enum logic {
    DERIV_PLUS  = 1'b0,
    DERIV_MINUS = 1'b1
  } deriv_sign_e;

  // Round half away from zero.
  function automatic int round_away(input real v);
    if (v >= 0.0) return $rtoi(v + 0.5);
    else          return -$rtoi(-v + 0.5);
  endfunction

  // One table entry: peak * sin(2*pi*idx/depth).
  function automatic int sine_entry(input int idx, input int depth, input int peak);
    real ang;
    ang = TWO_PI * real'(idx) / real'(depth);
    return round_away(real'(peak) * $sin(ang));
  endfunction

  // 2*pi scaled by 2^KQ; multiplying a residual count by this gives
  // radians * 2^(PHASE_W + KQ).
  function automatic int rad_scale();
    return round_away(TWO_PI * real'(2 ** KQ));
  endfunction

endpackage

// File: rtl/quad_rom.sv
module quad_rom
  import qtg_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int AMP_W  = 16
) (
  input  logic                     clk,
  input  logic                     en,
  input  logic [ADDR_W-1:0]        addr,
  output logic signed [AMP_W-1:0]  sin_q,
  output logic signed [AMP_W-1:0]  cos_q
);
  localparam int DEPTH   = 2 ** ADDR_W;
  localparam int QUARTER = DEPTH / 4;
  localparam int PEAK    = 2 ** (AMP_W - 1) - 1;

  logic signed [AMP_W-1:0] rom [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    localparam logic signed [AMP_W-1:0] VAL = AMP_W'(sine_entry(i, DEPTH, PEAK));
    assign rom[i] = VAL;
  end

  // Second port runs a quarter cycle ahead; natural wrap of ADDR_W bits.
  logic [ADDR_W-1:0] cos_addr;
  assign cos_addr = addr + ADDR_W'(QUARTER);

  always_ff @(posedge clk) begin
    if (en) begin
      sin_q <= rom[addr];
      cos_q <= rom[cos_addr];
    end
  end
endmodule

// File: rtl/resid_scale.sv
module resid_scale
  import qtg_pkg::*;
#(
  parameter int RES_W = 14,
  parameter int DEL_W = 30
) (
  input  logic                     clk,
  input  logic                     en,
  input  logic [RES_W-1:0]         resid,
  output logic signed [DEL_W-1:0]  delta
);
  localparam int K = rad_scale();

  logic [DEL_W-1:0] prod_u;
  assign prod_u = DEL_W'(resid) * DEL_W'(K);

  always_ff @(posedge clk) begin
    if (en) delta <= $signed(prod_u);
  end
endmodule

// File: rtl/taylor_mac.sv
module taylor_mac
  import qtg_pkg::*;
#(
  parameter int          AMP_W = 16,
  parameter int          DEL_W = 30,
  parameter int          SHIFT = 36,
  parameter deriv_sign_e SIGN  = DERIV_PLUS
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     en,
  input  logic signed [AMP_W-1:0]  base,
  input  logic signed [AMP_W-1:0]  deriv,
  input  logic signed [DEL_W-1:0]  delta,
  output logic signed [AMP_W-1:0]  y,
  output logic                     clip_hi,
  output logic                     clip_lo
);
  localparam int WIDE  = (DEL_W > SHIFT) ? DEL_W : SHIFT;
  localparam int ACC_W = AMP_W + WIDE + 2;
  localparam logic signed [ACC_W-1:0] HI_W = ACC_W'(2 ** (AMP_W - 1) - 1);
  localparam logic signed [ACC_W-1:0] LO_W = -ACC_W'(2 ** (AMP_W - 1));
  localparam logic signed [AMP_W-1:0] HI_Y = {1'b0, {(AMP_W-1){1'b1}}};
  localparam logic signed [AMP_W-1:0] LO_Y = {1'b1, {(AMP_W-1){1'b0}}};

  logic signed [ACC_W-1:0] base_w, deriv_w, delta_w, prod, term, acc, q;

  assign base_w  = ACC_W'(base) <<< SHIFT;
  assign deriv_w = ACC_W'(deriv);
  assign delta_w = ACC_W'(delta);
  assign prod    = delta_w * deriv_w;

  if (SIGN == DERIV_MINUS) begin : g_neg
    assign term = -prod;
  end else begin : g_pos
    assign term = prod;
  end

  assign acc = base_w + term + (ACC_W'(1) <<< (SHIFT - 1));
  assign q   = acc >>> SHIFT;

  assign clip_hi = (q > HI_W);
  assign clip_lo = (q < LO_W);

  function automatic logic signed [AMP_W-1:0] clamp(
    input logic signed [ACC_W-1:0] v, input logic hi, input logic lo);
    if (hi)      return HI_Y;
    else if (lo) return LO_Y;
    else         return v[AMP_W-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (rst)     y <= '0;
    else if (en) y <= clamp(q, clip_hi, clip_lo);
  end
endmodule

// File: rtl/quad_taylor_gen.sv
module quad_taylor_gen
  import qtg_pkg::*;
#(
  parameter int PHASE_W = 24,
  parameter int ADDR_W  = 10,
  parameter int AMP_W   = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic [PHASE_W-1:0]       phase_in,
  output logic                     out_valid,
  output logic signed [AMP_W-1:0]  sin_out,
  output logic signed [AMP_W-1:0]  cos_out
);
  localparam int RES_W = PHASE_W - ADDR_W;
  localparam int KW    = 16;
  localparam int DEL_W = RES_W + KW;
  localparam int SHIFT = PHASE_W + KQ;

  // Stage load strobes, named for the checker.
  logic ld1, ld2, ld3;
  logic v1, v2;

  assign ld1 = in_valid;
  assign ld2 = v1;
  assign ld3 = v2;

  // Stage 1: table lookups and residual capture.
  logic signed [AMP_W-1:0] sin_c1, cos_c1;
  logic [RES_W-1:0]        res1;

  quad_rom #(.ADDR_W(ADDR_W), .AMP_W(AMP_W)) u_rom (
    .clk   (clk),
    .en    (ld1),
    .addr  (phase_in[PHASE_W-1 -: ADDR_W]),
    .sin_q (sin_c1),
    .cos_q (cos_c1)
  );

  always_ff @(posedge clk) begin
    if (ld1) res1 <= phase_in[RES_W-1:0];
  end

  // Stage 2: residual to radians, coarse values carried along.
  logic signed [DEL_W-1:0] delta2;
  logic signed [AMP_W-1:0] sin_c2, cos_c2;

  resid_scale #(.RES_W(RES_W), .DEL_W(DEL_W)) u_scale (
    .clk   (clk),
    .en    (ld2),
    .resid (res1),
    .delta (delta2)
  );

  always_ff @(posedge clk) begin
    if (ld2) begin
      sin_c2 <= sin_c1;
      cos_c2 <= cos_c1;
    end
  end

  // Stage 3: multiply-add correction with clamping.
  logic sin_clip_hi, sin_clip_lo, cos_clip_hi, cos_clip_lo;

  taylor_mac #(.AMP_W(AMP_W), .DEL_W(DEL_W), .SHIFT(SHIFT), .SIGN(DERIV_PLUS)) u_sin_mac (
    .clk     (clk),
    .rst     (rst),
    .en      (ld3),
    .base    (sin_c2),
    .deriv   (cos_c2),
    .delta   (delta2),
    .y       (sin_out),
    .clip_hi (sin_clip_hi),
    .clip_lo (sin_clip_lo)
  );

  taylor_mac #(.AMP_W(AMP_W), .DEL_W(DEL_W), .SHIFT(SHIFT), .SIGN(DERIV_MINUS)) u_cos_mac (
    .clk     (clk),
    .rst     (rst),
    .en      (ld3),
    .base    (cos_c2),
    .deriv   (sin_c2),
    .delta   (delta2),
    .y       (cos_out),
    .clip_hi (cos_clip_hi),
    .clip_lo (cos_clip_lo)
  );

  // Valid pipeline.
  always_ff @(posedge clk) begin
    if (rst) begin
      v1        <= 1'b0;
      v2        <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      v1        <= in_valid;
      v2        <= v1;
      out_valid <= v2;
    end
  end
endmodule

// File: rtl/quad_taylor_gen_chk.sv
module quad_taylor_gen_chk #(
  parameter int AMP_W = 16
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     in_valid,
  input logic                     out_valid,
  input logic signed [AMP_W-1:0]  sin_out,
  input logic signed [AMP_W-1:0]  cos_out,
  input logic                     ld3,
  input logic                     sin_clip_hi,
  input logic                     cos_clip_lo
);
  localparam logic signed [AMP_W-1:0] HI_Y = {1'b0, {(AMP_W-1){1'b1}}};
  localparam logic signed [AMP_W-1:0] LO_Y = {1'b1, {(AMP_W-1){1'b0}}};

  logic [2:0] vsh;
  always_ff @(posedge clk) begin
    if (rst) vsh <= '0;
    else     vsh <= {vsh[1:0], in_valid};
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!out_valid && sin_out == '0 && cos_out == '0));

  assert_latency_R2: assert property (@(posedge clk) disable iff (rst)
    out_valid == vsh[2]);

  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !ld3 |=> ($stable(sin_out) && $stable(cos_out)));

  assert_sin_clip_R7: assert property (@(posedge clk) disable iff (rst)
    (ld3 && sin_clip_hi) |=> (sin_out == HI_Y));

  assert_cos_clip_R7: assert property (@(posedge clk) disable iff (rst)
    (ld3 && cos_clip_lo) |=> (cos_out == LO_Y));
endmodule

bind quad_taylor_gen quad_taylor_gen_chk #(.AMP_W(AMP_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .in_valid    (in_valid),
  .out_valid   (out_valid),
  .sin_out     (sin_out),
  .cos_out     (cos_out),
  .ld3         (ld3),
  .sin_clip_hi (sin_clip_hi),
  .cos_clip_lo (cos_clip_lo)
);

// File: tb/quad_taylor_gen_bench.sv
module quad_taylor_gen_bench;
  localparam real TWO_PI = 6.283185307179586;
  localparam real TOL    = 2.0;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic        in_valid = 1'b0;
  logic [23:0] phase_in = '0;
  logic        out_valid;
  logic signed [15:0] sin_out, cos_out;

  logic        n_in_valid = 1'b0;
  logic [23:0] n_phase = '0;
  logic        n_out_valid;
  logic signed [15:0] n_sin, n_cos;

  quad_taylor_gen u_quad_taylor_gen (
    .clk(clk), .rst(rst), .in_valid(in_valid), .phase_in(phase_in),
    .out_valid(out_valid), .sin_out(sin_out), .cos_out(cos_out));

  quad_taylor_gen #(.PHASE_W(24), .ADDR_W(6), .AMP_W(16)) u_quad_taylor_gen_narrow (
    .clk(clk), .rst(rst), .in_valid(n_in_valid), .phase_in(n_phase),
    .out_valid(n_out_valid), .sin_out(n_sin), .cos_out(n_cos));

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  localparam int NV = 16;
  localparam logic [23:0] VEC [NV] = '{
    24'h000000, 24'h000001, 24'h003FFF, 24'h012345,
    24'h0FFFFF, 24'h1ABCDE, 24'h3FFFFF, 24'h400000,
    24'h5A5A5A, 24'h7FFFFF, 24'h8CD123, 24'hA00000,
    24'hB7E151, 24'hC3FFFF, 24'hE12345, 24'hFFFFFF};

  function automatic int rnd(input real v);
    if (v >= 0.0) return $rtoi(v + 0.5);
    else          return -$rtoi(-v + 0.5);
  endfunction

  function automatic real ref_sin(input logic [23:0] p);
    return 32767.0 * $sin(TWO_PI * real'(p) / 16777216.0);
  endfunction

  function automatic real ref_cos(input logic [23:0] p);
    return 32767.0 * $cos(TWO_PI * real'(p) / 16777216.0);
  endfunction

  task automatic check_int(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_near(input string req, input int act, input real exp);
    real d;
    n_chk++;
    d = real'(act) - exp;
    if (d < 0.0) d = -d;
    if (d > TOL) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%f (tol %f)", req, act, exp, TOL);
    end
  endtask

  task automatic apply_one(input logic [23:0] p);
    @(negedge clk);
    in_valid = 1'b1; phase_in = p;
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic apply_narrow(input logic [23:0] p);
    @(negedge clk);
    n_in_valid = 1'b1; n_phase = p;
    @(negedge clk);
    n_in_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int last_s, last_c;

    // R1: reset state
    repeat (3) @(negedge clk);
    check_int("R1 out_valid", int'(out_valid), 0);
    check_int("R1 sin_out", int'(sin_out), 0);
    check_int("R1 cos_out", int'(cos_out), 0);
    rst = 1'b0;

    // R2/R3/R4/R6: stream the vector table back to back.
    for (int t = 0; t < NV + 3; t++) begin
      @(negedge clk);
      if (t >= 3) begin
        logic [23:0] p;
        p = VEC[t-3];
        check_int("R2 out_valid streaming", int'(out_valid), 1);
        check_near("R3 sine", int'(sin_out), ref_sin(p));
        if (p[23:22] == 2'b11) check_near("R6 cosine wrap", int'(cos_out), ref_cos(p));
        else                   check_near("R4 cosine", int'(cos_out), ref_cos(p));
      end
      if (t < NV) begin
        in_valid = 1'b1; phase_in = VEC[t];
      end else begin
        in_valid = 1'b0;
      end
    end

    // R2: gap pattern 1,0,1 is preserved.
    @(negedge clk); in_valid = 1'b1; phase_in = 24'h123456;
    @(negedge clk); in_valid = 1'b0;
    @(negedge clk); in_valid = 1'b1; phase_in = 24'h654321;
    @(negedge clk); in_valid = 1'b0;
    check_int("R2 gap first", int'(out_valid), 1);
    check_near("R3 gap first sine", int'(sin_out), ref_sin(24'h123456));
    @(negedge clk);
    check_int("R2 gap bubble", int'(out_valid), 0);
    @(negedge clk);
    check_int("R2 gap second", int'(out_valid), 1);
    check_near("R4 gap second cosine", int'(cos_out), ref_cos(24'h654321));

    // R5: zero residual gives exact table entries.
    foreach (VEC[k]) begin
      if (VEC[k][13:0] == 14'd0) begin
        int idx;
        idx = int'(VEC[k][23:14]);
        apply_one(VEC[k]);
        check_int("R5 exact sine", int'(sin_out), rnd(32767.0 * $sin(TWO_PI * real'(idx) / 1024.0)));
        check_int("R5 exact cosine", int'(cos_out),
                  rnd(32767.0 * $sin(TWO_PI * real'((idx + 256) % 1024) / 1024.0)));
      end
    end
    apply_one(24'd100 << 14);
    check_int("R5 exact sine idx100", int'(sin_out), rnd(32767.0 * $sin(TWO_PI * 100.0 / 1024.0)));
    check_int("R5 exact cosine idx100", int'(cos_out), rnd(32767.0 * $sin(TWO_PI * 356.0 / 1024.0)));

    // R8: phase changes with in_valid low leave outputs untouched.
    last_s = int'(sin_out);
    last_c = int'(cos_out);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      phase_in = 24'h0ABCDE + 24'(k * 24'h111111);
    end
    check_int("R8 hold valid", int'(out_valid), 0);
    check_int("R8 hold sine", int'(sin_out), last_s);
    check_int("R8 hold cosine", int'(cos_out), last_c);

    // R7: clamping, narrow table instance.
    apply_narrow(24'h3FFFFF);
    check_int("R7 sine clip high", int'(n_sin), 32767);
    apply_narrow(24'hBFFFFF);
    check_int("R7 sine clip low", int'(n_sin), -32768);
    apply_narrow(24'h7FFFFF);
    check_int("R7 cosine clip low", int'(n_cos), -32768);
    apply_narrow(24'hFFFFFF);
    check_int("R7 cosine clip high", int'(n_cos), 32767);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule